// File: doc/BRIEF.md
# Serial Shift Interface with Edge Counter

This block is a byte-wide serial shifter meant to carry three-wire (SPI-like) and two-wire (I2C-like) traffic under software control. A single 8-bit shift register is the only data store: bus writes load it, bus reads return it, and each clock event moves it one place to the left, taking the sampled serial input into bit 0. Bit 7 drives the serial output pin through an output latch. The latch makes the output change on the opposite serial-clock edge from the one that samples the input.

The clock event that shifts the register comes from one of four sources, set by a 2-bit select field. Software can issue a strobe through a control write, a single-cycle timer pulse can be fed in, or the rising or falling edge of the external serial clock can be used. A 4-bit counter counts clock events and raises an overflow flag when it wraps. Two more sticky flags report a bus start condition and a bus stop condition, and a collision bit compares the outgoing MSB with the level on the data line. Software clears each flag by writing a 1 to its bit.

Bus map: address 0 is the shift register, address 1 is status, and address 2 is control. Address 3 reads as zero and ignores writes. Reads are combinational and writes take effect at the clock edge.

Top module: `ser_shift_if`

## Requirements
- R1: After reset, data, status and control all read 0 and `ser_do` is 0. Address 0 reads and writes the shift register itself, and a write is visible at the next edge.
- R2: When an address-0 write and a shift event fall in the same cycle, the register takes the written value and no shift happens.
- R3: A shift event moves the register left by one, with the sampled `ser_di` entering bit 0. Control bits [3:2] select the event source: 00 = control write with bit 1 set (strobe), 01 = `tmr_match` pulse, 10 = rising edge of `ser_ck`, 11 = falling edge of `ser_ck`.
- R4: Control bits [5:4] select the wire mode: 00 = off, 01 = three-wire, 1x = two-wire. With the mode off, `ser_ck` and `ser_di` still shift the register.
- R5: With select 00 or 01, `ser_do` always follows bit 7. With select 10, `ser_do` follows bit 7 while the synchronised `ser_ck` is low and holds while it is high. With select 11, `ser_do` follows bit 7 while `ser_ck` is high and holds while it is low. A write while `ser_do` follows bit 7 shows on `ser_do` immediately.
- R6: The 4-bit counter (status [3:0]) increments on every clock event. With select 1x, both `ser_ck` edges and the strobe count as events. A wrap from 15 to 0 sets the overflow flag.
- R7: Status layout: [7] start flag, [6] overflow flag, [5] stop flag, [4] collision bit (read-only), [3:0] counter. A status write loads the counter from bits [3:0] and clears each flag whose bit is 1. Writing 0 to a flag bit leaves the flag unchanged. `irq_start`, `irq_ovf` and `irq_stop` mirror the flags.
- R8: In two-wire mode, a falling `ser_di` while `ser_ck` is high sets the start flag, and a rising `ser_di` while `ser_ck` is high sets the stop flag. In other modes, data edges set neither flag.
- R9: When the mode is not two-wire and the select is 1x, any `ser_ck` edge sets the start flag.
- R10: The collision bit reads 1 exactly when bit 7 differs from the sampled `ser_di` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address (0 data, 1 status, 2 control) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ser_ck | input | 1 | Serial clock line (three-wire clock or two-wire clock) |
| ser_di | input | 1 | Serial data line input |
| tmr_match | input | 1 | Single-cycle timer compare-match pulse |
| ser_do | output | 1 | Serial data output through the output latch |
| irq_start | output | 1 | Start flag |
| irq_ovf | output | 1 | Counter overflow flag |
| irq_stop | output | 1 | Stop flag |

## Verification
Bus writes and timer pulses act at the next clock edge, so their results are read back one cycle later. A change on `ser_ck` or `ser_di` passes through one sampling register before the edge logic sees it and updates state at the edge after that, and the latch opening follows `ser_ck` one edge after the change. The bench therefore holds each line change for three cycles before it samples. Results are always sampled on the falling clock edge, halfway between the edges that drive the state.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    localparam int DW    = 8;
    localparam int CNT_W = 4;
    localparam int AW    = 2;

    localparam logic [AW-1:0] ADR_DATA = 2'd0;
    localparam logic [AW-1:0] ADR_STAT = 2'd1;
    localparam logic [AW-1:0] ADR_CTRL = 2'd2;

    typedef enum logic [1:0] {
        CS_SOFT     = 2'b00,
        CS_TIMER    = 2'b01,
        CS_EXT_RISE = 2'b10,
        CS_EXT_FALL = 2'b11
    } csel_e;

    typedef enum logic [1:0] {
        WM_OFF   = 2'b00,
        WM_THREE = 2'b01,
        WM_TWO_A = 2'b10,
        WM_TWO_B = 2'b11
    } wmode_e;

    typedef struct packed {
        logic             start;
        logic             ovf;
        logic             stop;
        logic             coll;
        logic [CNT_W-1:0] cnt;
    } status_t;

    typedef struct packed {
        wmode_e mode;
        csel_e  csel;
    } ctrl_t;

    function automatic logic is_two_wire(input wmode_e m);
        return m[1];
    endfunction

    function automatic logic is_external(input csel_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/ssi_line_mon.sv
module ssi_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic ck_in,
    input  logic di_in,
    output logic ck_lvl,
    output logic di_lvl,
    output logic ck_rise,
    output logic ck_fall,
    output logic di_rise,
    output logic di_fall
);
    logic ck_prev, di_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_lvl  <= 1'b0;
            di_lvl  <= 1'b0;
            ck_prev <= 1'b0;
            di_prev <= 1'b0;
        end else begin
            ck_lvl  <= ck_in;
            di_lvl  <= di_in;
            ck_prev <= ck_lvl;
            di_prev <= di_lvl;
        end
    end

    assign ck_rise = ck_lvl & ~ck_prev;
    assign ck_fall = ~ck_lvl & ck_prev;
    assign di_rise = di_lvl & ~di_prev;
    assign di_fall = ~di_lvl & di_prev;
endmodule

// File: rtl/ssi_clk_sel.sv
module ssi_clk_sel
    import ssi_pkg::*;
(
    input  csel_e csel,
    input  logic  ck_rise,
    input  logic  ck_fall,
    input  logic  tmr_pulse,
    input  logic  sw_strobe,
    output logic  shift_ev,
    output logic  count_ev
);
    always_comb begin
        unique case (csel)
            CS_SOFT:     shift_ev = sw_strobe;
            CS_TIMER:    shift_ev = tmr_pulse;
            CS_EXT_RISE: shift_ev = ck_rise;
            default:     shift_ev = ck_fall;
        endcase
        if (is_external(csel))
            count_ev = ck_rise | ck_fall | sw_strobe;
        else
            count_ev = shift_ev;
    end
endmodule

// File: rtl/ssi_out_latch.sv
module ssi_out_latch
    import ssi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  csel_e csel,
    input  logic  ck_lvl,
    input  logic  msb,
    output logic  open_o,
    output logic  dout
);
    logic held;

    // Open in the half period that precedes the sampling edge.
    assign open_o = !is_external(csel) || (ck_lvl == csel[0]);
    assign dout   = open_o ? msb : held;

    always_ff @(posedge clk) begin
        if (rst) held <= 1'b0;
        else     held <= dout;
    end
endmodule

// File: rtl/ser_shift_if.sv
module ser_shift_if
    import ssi_pkg::*;
#(
    parameter int DATA_W = ssi_pkg::DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_ck,
    input  logic              ser_di,
    input  logic              tmr_match,
    output logic              ser_do,
    output logic              irq_start,
    output logic              irq_ovf,
    output logic              irq_stop
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_q, ovf_q, stop_q;
    ctrl_t             ctrl_q;
    status_t           stat;

    logic ck_lvl, di_lvl, ck_rise, ck_fall, di_rise, di_fall;
    logic shift_ev, count_ev, lat_open;
    logic wr_data, wr_stat, wr_ctrl, sw_strobe;
    logic start_set, stop_set, ovf_set;

    assign wr_data   = bus_we && (bus_addr == ADR_DATA);
    assign wr_stat   = bus_we && (bus_addr == ADR_STAT);
    assign wr_ctrl   = bus_we && (bus_addr == ADR_CTRL);
    assign sw_strobe = wr_ctrl && bus_wdata[1];

    ssi_line_mon u_mon (
        .clk(clk), .rst(rst), .ck_in(ser_ck), .di_in(ser_di),
        .ck_lvl(ck_lvl), .di_lvl(di_lvl),
        .ck_rise(ck_rise), .ck_fall(ck_fall),
        .di_rise(di_rise), .di_fall(di_fall)
    );

    ssi_clk_sel u_sel (
        .csel(ctrl_q.csel), .ck_rise(ck_rise), .ck_fall(ck_fall),
        .tmr_pulse(tmr_match), .sw_strobe(sw_strobe),
        .shift_ev(shift_ev), .count_ev(count_ev)
    );

    ssi_out_latch u_lat (
        .clk(clk), .rst(rst), .csel(ctrl_q.csel), .ck_lvl(ck_lvl),
        .msb(shreg[DATA_W-1]), .open_o(lat_open), .dout(ser_do)
    );

    always_comb begin
        if (is_two_wire(ctrl_q.mode))
            start_set = di_fall && ck_lvl;
        else
            start_set = is_external(ctrl_q.csel) && (ck_rise || ck_fall);
        stop_set = is_two_wire(ctrl_q.mode) && di_rise && ck_lvl;
        ovf_set  = count_ev && (cnt_q == CNT_MAX) && !wr_stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            cnt_q   <= '0;
            start_q <= 1'b0;
            ovf_q   <= 1'b0;
            stop_q  <= 1'b0;
            ctrl_q  <= '{mode: WM_OFF, csel: CS_SOFT};
        end else begin
            if (wr_data)
                shreg <= bus_wdata;
            else if (shift_ev)
                shreg <= {shreg[DATA_W-2:0], di_lvl};

            if (wr_stat)
                cnt_q <= bus_wdata[CNT_W-1:0];
            else if (count_ev)
                cnt_q <= cnt_q + 1'b1;

            start_q <= start_set || (start_q && !(wr_stat && bus_wdata[7]));
            ovf_q   <= ovf_set   || (ovf_q   && !(wr_stat && bus_wdata[6]));
            stop_q  <= stop_set  || (stop_q  && !(wr_stat && bus_wdata[5]));

            if (wr_ctrl)
                ctrl_q <= '{mode: wmode_e'(bus_wdata[5:4]), csel: csel_e'(bus_wdata[3:2])};
        end
    end

    always_comb begin
        stat.start = start_q;
        stat.ovf   = ovf_q;
        stat.stop  = stop_q;
        stat.coll  = shreg[DATA_W-1] ^ di_lvl;
        stat.cnt   = cnt_q;
        unique case (bus_addr)
            ADR_DATA: bus_rdata = shreg;
            ADR_STAT: bus_rdata = DATA_W'(stat);
            ADR_CTRL: bus_rdata = DATA_W'({ctrl_q, 2'b00});
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_start = start_q;
    assign irq_ovf   = ovf_q;
    assign irq_stop  = stop_q;
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker
    import ssi_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] shreg,
    input logic [3:0]    cnt_q,
    input logic          ovf_q,
    input logic          start_q,
    input logic          stop_q,
    input logic          shift_ev,
    input logic          count_ev,
    input logic          di_lvl,
    input logic          lat_open,
    input logic          ser_do,
    input ctrl_t         ctrl_q
);
    logic wr_d, wr_s;
    assign wr_d = bus_we && (bus_addr == ADR_DATA);
    assign wr_s = bus_we && (bus_addr == ADR_STAT);

    a_r2_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_d |=> shreg == $past(bus_wdata));

    a_r3_left_shift: assert property (@(posedge clk) disable iff (rst)
        (shift_ev && !wr_d) |=> shreg == {$past(shreg[DW-2:0]), $past(di_lvl)});

    a_r5_internal_follows: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.csel[1] |-> ser_do == shreg[DW-1]);

    a_r5_closed_holds: assert property (@(posedge clk) disable iff (rst)
        (!lat_open && $past(!lat_open)) |-> $stable(ser_do));

    a_r6_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (count_ev && cnt_q == 4'hF && !wr_s) |=> (ovf_q && cnt_q == 4'h0));

    a_r7_start_sticky: assert property (@(posedge clk) disable iff (rst)
        (start_q && !(wr_s && bus_wdata[7])) |=> start_q);

    a_r8_no_stop_outside_two_wire: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.mode[1] && !stop_q) |=> !stop_q);
endmodule

bind ser_shift_if ssi_checker u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .shreg(shreg), .cnt_q(cnt_q), .ovf_q(ovf_q),
    .start_q(start_q), .stop_q(stop_q), .shift_ev(shift_ev),
    .count_ev(count_ev), .di_lvl(di_lvl), .lat_open(lat_open),
    .ser_do(ser_do), .ctrl_q(ctrl_q)
);

// File: tb/ser_shift_if_bench.sv
`timescale 1ns/1ps
module ser_shift_if_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_ck = 1'b0, ser_di = 1'b0, tmr_match = 1'b0;
    logic       ser_do, irq_start, irq_ovf, irq_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ser_shift_if u_ser_shift_if (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_ck(ser_ck),
        .ser_di(ser_di), .tmr_match(tmr_match), .ser_do(ser_do),
        .irq_start(irq_start), .irq_ovf(irq_ovf), .irq_stop(irq_stop)
    );

    // load, serial input bits (MSB first), shift count, expected result
    localparam logic [27:0] VEC [5] = '{
        {8'hA5, 8'hFF, 4'd4, 8'h5F},
        {8'h81, 8'h00, 4'd1, 8'h02},
        {8'h00, 8'hA0, 4'd3, 8'h05},
        {8'hF0, 8'h0F, 4'd8, 8'h0F},
        {8'h12, 8'hC0, 4'd2, 8'h4B}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic ck_set(input logic v);
        ser_ck = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic di_set(input logic v);
        ser_di = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, r); check("R1 data reset", r, 8'h00);
        rd(2'd1, r); check("R1 status reset", r, 8'h00);
        rd(2'd2, r); check("R1 control reset", r, 8'h00);
        check("R1 ser_do reset", {7'b0, ser_do}, 8'h00);

        // R3 software strobe vectors
        for (int v = 0; v < 5; v++) begin
            bus_wr(2'd0, VEC[v][27:20]);
            bus_wr(2'd1, 8'hE0);
            for (int i = 0; i < int'(VEC[v][11:8]); i++) begin
                ser_di = VEC[v][19 - i];
                @(negedge clk);
                bus_wr(2'd2, 8'h02);
            end
            rd(2'd0, r); check("R3 strobe shift", r, VEC[v][7:0]);
            rd(2'd1, r); check("R6 count per strobe", {4'h0, r[3:0]}, {4'h0, VEC[v][11:8]});
        end

        // R3 timer pulse source
        bus_wr(2'd2, 8'h04);
        rd(2'd2, r); check("R4 control readback", r, 8'h04);
        bus_wr(2'd0, 8'h40);
        ser_di = 1'b1; @(negedge clk);
        tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
        rd(2'd0, r); check("R3 timer shift", r, 8'h81);

        // R2 write beats shift in same cycle
        ser_di = 1'b0; @(negedge clk);
        tmr_match = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h3C;
        @(negedge clk);
        tmr_match = 1'b0; bus_we = 1'b0;
        rd(2'd0, r); check("R2 write wins", r, 8'h3C);

        // R4/R5/R6/R9 external rising edge, wire mode off
        bus_wr(2'd2, 8'h08);
        bus_wr(2'd0, 8'h80);
        di_set(1'b0);
        check("R5 open while ck low", {7'b0, ser_do}, 8'h01);
        bus_wr(2'd1, 8'hE0);
        ck_set(1'b1);
        rd(2'd0, r); check("R4 ext rise shift in mode off", r, 8'h00);
        check("R5 latch holds while ck high", {7'b0, ser_do}, 8'h01);
        rd(2'd1, r); check("R6 count ext rise", {4'h0, r[3:0]}, 8'h01);
        check("R9 ck edge sets start", {7'b0, r[7]}, 8'h01);
        ck_set(1'b0);
        check("R5 output changes on fall", {7'b0, ser_do}, 8'h00);
        rd(2'd1, r); check("R6 both ext edges count", {4'h0, r[3:0]}, 8'h02);
        rd(2'd0, r); check("R3 fall no shift with select 10", r, 8'h00);
        ck_set(1'b1);
        bus_wr(2'd0, 8'h80);
        check("R5 closed latch ignores write", {7'b0, ser_do}, 8'h00);
        ck_set(1'b0);
        check("R5 reopened latch shows msb", {7'b0, ser_do}, 8'h01);
        bus_wr(2'd0, 8'h00);
        check("R5 open latch write immediate", {7'b0, ser_do}, 8'h00);

        // R3 external falling edge
        bus_wr(2'd2, 8'h0C);
        bus_wr(2'd0, 8'h01);
        di_set(1'b1);
        ck_set(1'b1);
        rd(2'd0, r); check("R3 rise no shift with select 11", r, 8'h01);
        ck_set(1'b0);
        rd(2'd0, r); check("R3 fall shift with select 11", r, 8'h03);

        // R6/R7 overflow and write-one-to-clear
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd1, 8'h0F);
        bus_wr(2'd2, 8'h02);
        rd(2'd1, r);
        check("R6 wrap sets overflow", {7'b0, r[6]}, 8'h01);
        check("R6 wrap count zero", {4'h0, r[3:0]}, 8'h00);
        check("R7 zero write keeps start", {7'b0, r[7]}, 8'h01);
        check("R7 irq_ovf mirrors flag", {7'b0, irq_ovf}, 8'h01);
        bus_wr(2'd1, 8'h40);
        rd(2'd1, r);
        check("R7 clear overflow", {7'b0, r[6]}, 8'h00);
        check("R7 start untouched", {7'b0, r[7]}, 8'h01);
        bus_wr(2'd1, 8'h80);
        rd(2'd1, r); check("R7 clear start", {7'b0, r[7]}, 8'h00);

        // R8 two-wire start and stop
        bus_wr(2'd1, 8'hE0);
        bus_wr(2'd2, 8'h20);
        ck_set(1'b1);
        rd(2'd1, r); check("R8 clock edge alone no start", {5'b0, r[7:5]}, 8'h00);
        di_set(1'b0);
        rd(2'd1, r); check("R8 start on data fall", {7'b0, r[7]}, 8'h01);
        di_set(1'b1);
        rd(2'd1, r); check("R8 stop on data rise", {7'b0, r[5]}, 8'h01);
        check("R8 irq_stop", {7'b0, irq_stop}, 8'h01);
        ck_set(1'b0);

        // R8 data edges ignored in three-wire mode
        bus_wr(2'd1, 8'hE0);
        bus_wr(2'd2, 8'h10);
        ck_set(1'b1);
        di_set(1'b0);
        di_set(1'b1);
        rd(2'd1, r); check("R8 three-wire ignores data edges", {5'b0, r[7:5]}, 8'h00);
        ck_set(1'b0);

        // R10 collision bit
        bus_wr(2'd0, 8'h80);
        rd(2'd1, r); check("R10 match no collision", {7'b0, r[4]}, 8'h00);
        di_set(1'b0);
        rd(2'd1, r); check("R10 mismatch collision", {7'b0, r[4]}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule